// File: doc/BRIEF.md
# Clocked Pulse Delay Filter

This block delays a single-bit signal by a fixed number of clock cycles. It can also filter out short pulses on the way. The input is sampled on every rising edge and pushed into a line of sample registers. The output is a register loaded from the oldest stored sample. A mode select picks one of two behaviours:

- **Transport mode** is a plain delay line. Every pulse, even one cycle long, reappears at the output unchanged in width.
- **Inertial mode** adds a minimum pulse width. The output takes a new level only when that level was held on the input for at least `REJECT` consecutive samples, counted from the delayed sample toward newer ones. A shorter excursion is swallowed and the output keeps its previous level.

Both the propagation delay `DELAY` and the rejection width `REJECT` are elaboration parameters. `REJECT` defaults to `DELAY`.

Typical uses are modelling board or wire delay, with its glitches kept, and suppressing runt pulses before a slow consumer. The mode can be changed on the fly. Samples already in flight are not flushed. Each one is judged under whichever mode is current when it reaches the output.

Top module: `pulse_delay_filter`

## Requirements
- R1: While `rst` is high at a rising edge, all stored samples and `dout` are cleared to 0 and the mode register is set to inertial. After `rst` is released, no level stored before the reset appears on `dout`.
- R2: In transport mode (`mode_sel` = 1), the value of `din` sampled at rising edge k is on `dout` after edge k+`DELAY`, for pulses of any width including one cycle.
- R3: In inertial mode (`mode_sel` = 0), take a level that was sampled at edges k through k+`REJECT`-1. That level is on `dout` after edge k+`DELAY`, the same latency as in transport mode.
- R4: In inertial mode, an input excursion shorter than `REJECT` samples never reaches `dout`. `dout` keeps its prior level instead.
- R5: `mode_sel` is registered. The value sampled at edge k decides the output update at edge k+1. A mode change does not clear the stored samples: samples already in the line are judged under the new mode.
- R6: `REJECT` defaults to `DELAY`. With `DELAY` = `REJECT` = 20, a 10-cycle low glitch in a steady high input leaves `dout` steady in inertial mode. In transport mode the full 10-cycle glitch is reproduced 20 cycles late.
- R7: A configuration with `DELAY` < 1, `REJECT` < 1 or `REJECT` > `DELAY` is flagged at elaboration. A legal configuration with `REJECT` < `DELAY` passes a pulse of exactly `REJECT` cycles.
- R8: Whenever `dout` changes, its new value equals the input sample taken `DELAY` edges earlier. The filter never produces a level the input did not have at that delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Data input, sampled every cycle |
| mode_sel | input | 1 | 1 = transport, 0 = inertial |
| dout | output | 1 | Delayed, optionally filtered output |

## Verification
A sample taken at rising edge k shows up on `dout` after edge k+`DELAY`. Reaching the last stored sample takes `DELAY`-1 register stages, and the output register adds one more. A mode value sampled at edge k governs only the update at edge k+1.

The bench drives `din` and `mode_sel` at falling edges and logs each value against the index of the rising edge that captures it. From that log, a model built directly on R2 to R5 predicts `dout` after each rising edge. The bench compares at the following falling edge, so every comparison lines up with the edge whose update it judges.

Hand-counted windows check the glitch example, the mode switch with pulses in flight, and the reset flush. Each window is long enough to cover the full `DELAY` latency.

// File: rtl/pulse_delay_filter_pkg.sv
package pulse_delay_filter_pkg;

    typedef enum logic {
        MODE_INERTIAL  = 1'b0,
        MODE_TRANSPORT = 1'b1
    } dly_mode_e;

    typedef struct packed {
        logic      dout;
        dly_mode_e mode;
    } core_state_t;

endpackage

// File: rtl/pdf_tap_line.sv
// Line of input samples; bit 0 holds the newest, bit DEPTH-1 the oldest.
module pdf_tap_line #(
    parameter int DEPTH = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic [DEPTH-1:0] line_q
);

    logic [DEPTH-1:0] line_d;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                line_d = din;
            end
        end else begin : g_multi
            always_comb begin
                line_d = {line_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

endmodule

// File: rtl/pdf_window_judge.sv
// Looks at the SPAN samples starting at the oldest one and reports whether
// they all carry the same level as the oldest sample.
module pdf_window_judge #(
    parameter int DEPTH = 20,
    parameter int SPAN  = 20
) (
    input  logic [DEPTH-1:0] line,
    output logic             tap,
    output logic             settled
);

    localparam int LAST = DEPTH - 1;

    logic all_hi;
    logic all_lo;

    always_comb begin
        all_hi = 1'b1;
        all_lo = 1'b1;
        for (int i = 0; i < SPAN; i++) begin
            all_hi = all_hi & line[LAST-i];
            all_lo = all_lo & ~line[LAST-i];
        end
        tap     = line[LAST];
        settled = all_hi | all_lo;
    end

endmodule

// File: rtl/pulse_delay_filter.sv
module pulse_delay_filter
    import pulse_delay_filter_pkg::*;
#(
    parameter int DELAY  = 20,
    parameter int REJECT = DELAY
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic mode_sel,
    output logic dout
);

    // R7: illegal configurations are stopped at elaboration
    generate
        if ((DELAY < 1) || (REJECT < 1) || (REJECT > DELAY)) begin : g_bad_cfg
            $error("pulse_delay_filter: need 1 <= REJECT <= DELAY");
        end
    endgenerate

    localparam int SPAN = (REJECT < 1) ? 1 : ((REJECT > DELAY) ? DELAY : REJECT);

    logic [DELAY-1:0] line_w;
    logic             tap_w;
    logic             settled_w;
    logic             mode_w;

    core_state_t state_d;
    core_state_t state_q;

    pdf_tap_line #(
        .DEPTH (DELAY)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .line_q (line_w)
    );

    pdf_window_judge #(
        .DEPTH (DELAY),
        .SPAN  (SPAN)
    ) u_judge (
        .line    (line_w),
        .tap     (tap_w),
        .settled (settled_w)
    );

    always_comb begin
        state_d      = state_q;
        state_d.mode = dly_mode_e'(mode_sel);
        if ((state_q.mode == MODE_TRANSPORT) || settled_w) begin
            state_d.dout = tap_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.dout <= 1'b0;
            state_q.mode <= MODE_INERTIAL;
        end else begin
            state_q <= state_d;
        end
    end

    assign mode_w = state_q.mode;
    assign dout   = state_q.dout;

endmodule

// File: rtl/pulse_delay_filter_chk.sv
module pulse_delay_filter_chk (
    input logic clk,
    input logic rst,
    input logic mode_sel,
    input logic dout,
    input logic tap,
    input logic settled,
    input logic mode_q
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dout == 1'b0) && (mode_q == 1'b0));

    p_transport_copy_r2: assert property (@(posedge clk) disable iff (rst)
        mode_q |=> dout == $past(tap));

    p_inertial_pass_r3: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && settled) |=> dout == $past(tap));

    p_inertial_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !settled) |=> $stable(dout));

    p_mode_follow_r5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> mode_q == $past(mode_sel));

    p_no_invent_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> dout == $past(tap));

endmodule

bind pulse_delay_filter pulse_delay_filter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .dout     (dout),
    .tap      (tap_w),
    .settled  (settled_w),
    .mode_q   (mode_w)
);

// File: tb/pulse_delay_filter_test.sv
module pulse_delay_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int DA = 20;
    localparam int RA = 20;
    localparam int DB = 8;
    localparam int RB = 3;

    typedef struct packed {
        logic       m;
        logic       d;
        logic [7:0] len;
    } seg_t;

    // mode (1 = transport), input level, length in cycles
    localparam seg_t SEGS [16] = '{
        '{1'b0, 1'b0, 8'd25}, '{1'b0, 1'b1, 8'd2},  '{1'b0, 1'b0, 8'd5},
        '{1'b0, 1'b1, 8'd3},  '{1'b0, 1'b0, 8'd4},  '{1'b0, 1'b1, 8'd19},
        '{1'b0, 1'b0, 8'd30}, '{1'b0, 1'b1, 8'd20}, '{1'b0, 1'b0, 8'd25},
        '{1'b1, 1'b1, 8'd1},  '{1'b1, 1'b0, 8'd3},  '{1'b1, 1'b1, 8'd4},
        '{1'b1, 1'b0, 8'd25}, '{1'b0, 1'b1, 8'd50}, '{1'b0, 1'b0, 8'd2},
        '{1'b0, 1'b1, 8'd30}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic mode_sel = 1'b0;
    logic dout_a;
    logic dout_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int cyc    = 0;
    logic exp_a = 1'b0;
    logic exp_b = 1'b0;
    logic prev_a = 1'b0;
    logic samp [4096];
    logic msel [4096];

    always #(CLK_PERIOD/2) clk = ~clk;

    // R6: default REJECT (= DELAY) instance; R7: legal REJECT < DELAY instance
    pulse_delay_filter uut (
        .clk(clk), .rst(rst), .din(din), .mode_sel(mode_sel), .dout(dout_a)
    );

    pulse_delay_filter #(.DELAY(DB), .REJECT(RB)) uut_short (
        .clk(clk), .rst(rst), .din(din), .mode_sel(mode_sel), .dout(dout_b)
    );

    function automatic logic get_s(int i);
        return (i < 0) ? 1'b0 : samp[i];
    endfunction

    function automatic logic get_m(int n);
        return (n == 0) ? 1'b0 : msel[n-1];
    endfunction

    function automatic logic model(int n, int d, int r, logic prev);
        logic tap;
        tap = get_s(n - d);
        if (get_m(n)) return tap;
        for (int j = 0; j < r; j++) begin
            if (get_s(n - d + j) != tap) return prev;
        end
        return tap;
    endfunction

    function automatic string tag_of(int n, int d, int r, logic prev);
        if (get_m(n)) return "R2";
        if (model(n, d, r, prev) == get_s(n - d)) return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input string what, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0b (edge %0d)", tag, what, act, expv, cyc);
        end
    endtask

    task automatic check_int(input string tag, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Called at a falling edge: drives one sample, then checks after the rising edge.
    task automatic drive_cycle(input logic d, input logic m);
        string ta;
        string tb;
        int n;
        n = cyc;
        samp[n] = d;
        msel[n] = m;
        din = d;
        mode_sel = m;
        @(posedge clk);
        ta = tag_of(n, DA, RA, exp_a);
        tb = tag_of(n, DB, RB, exp_b);
        exp_a = model(n, DA, RA, exp_a);
        exp_b = model(n, DB, RB, exp_b);
        cyc++;
        @(negedge clk);
        check(ta, "dout long", dout_a, exp_a);
        check(tb, "dout short", dout_b, exp_b);
        if (dout_a !== prev_a) begin
            check("R8", "changed value vs delayed sample", dout_a, get_s(n - DA));
        end
        prev_a = dout_a;
    endtask

    task automatic restart_model();
        for (int i = 0; i < 4096; i++) begin
            samp[i] = 1'b0;
            msel[i] = 1'b0;
        end
        cyc = 0;
        exp_a = 1'b0;
        exp_b = 1'b0;
        prev_a = 1'b0;
    endtask

    initial begin
        int cnt;
        logic [15:0] lfsr;
        logic lvl;
        logic md;
        int w;
        restart_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset dout long", dout_a, 1'b0);
        check("R1", "reset dout short", dout_b, 1'b0);
        rst = 1'b0;

        // stimulus table walk
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < int'(SEGS[s].len); k++) begin
                drive_cycle(SEGS[s].d, SEGS[s].m);
            end
        end

        // R6: 10-cycle low glitch, inertial then transport
        for (int pass = 0; pass < 2; pass++) begin
            md = (pass == 1);
            for (int k = 0; k < 45; k++) drive_cycle(1'b1, md);
            cnt = 0;
            for (int k = 0; k < 10; k++) begin
                drive_cycle(1'b0, md);
                if (dout_a == 1'b0) cnt++;
            end
            for (int k = 0; k < 45; k++) begin
                drive_cycle(1'b1, md);
                if (dout_a == 1'b0) cnt++;
            end
            check_int("R6", md ? "glitch low cycles transport" : "glitch low cycles inertial",
                      cnt, md ? 10 : 0);
        end

        // R5: 2-cycle pulse launched in transport, mode drops to inertial in flight
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 12; k++) drive_cycle(1'b0, 1'b1);
            cnt = 0;
            for (int k = 0; k < 2; k++) begin
                drive_cycle(1'b1, 1'b1);
                if (dout_b) cnt++;
            end
            for (int k = 0; k < 14; k++) begin
                drive_cycle(1'b0, (pass == 1));
                if (dout_b) cnt++;
            end
            check_int(pass == 0 ? "R5" : "R2",
                      pass == 0 ? "pulse re-judged after switch" : "pulse kept in transport",
                      cnt, (pass == 0) ? 0 : 2);
        end

        // R7 / R3: pulse of exactly REJECT passes on the short instance; R4: one shorter is dropped
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 12; k++) drive_cycle(1'b0, 1'b0);
            cnt = 0;
            for (int k = 0; k < RB - pass; k++) begin
                drive_cycle(1'b1, 1'b0);
                if (dout_b) cnt++;
            end
            for (int k = 0; k < 14; k++) begin
                drive_cycle(1'b0, 1'b0);
                if (dout_b) cnt++;
            end
            check_int(pass == 0 ? "R7" : "R4",
                      pass == 0 ? "pulse width REJECT passes" : "pulse width REJECT-1 dropped",
                      cnt, (pass == 0) ? RB : 0);
        end

        // random pulse trains of mixed widths, occasional mode flips
        lfsr = 16'hACE1;
        lvl = 1'b0;
        md = 1'b0;
        while (cyc < 3300) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            w = int'(lfsr[4:0]) + 1;
            if (lfsr[9:7] == 3'd0) md = ~md;
            lvl = ~lvl;
            for (int k = 0; k < w; k++) drive_cycle(lvl, md);
        end

        // R1: reset in the middle of traffic flushes the line
        for (int k = 0; k < 30; k++) drive_cycle(1'b1, 1'b1);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "mid reset dout long", dout_a, 1'b0);
        check("R1", "mid reset dout short", dout_b, 1'b0);
        restart_model();
        rst = 1'b0;
        cnt = 0;
        for (int k = 0; k < 25; k++) begin
            drive_cycle(1'b0, 1'b1);
            if (dout_a || dout_b) cnt++;
        end
        check_int("R1", "stale highs after reset", cnt, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1-watchdog run: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule